// File: doc/BRIEF.md
# Camera Frame and Line Capture Machine

This block sits right behind an image sensor's parallel output. The sensor's pixel clock drives it. It watches the sensor's frame and line qualifier strobes and forwards one pixel word to a downstream sink on every clock in which a line is active inside a frame. Along with each word it gives framing marks: the first word of a frame, the first word of a line, and a single-cycle end-of-frame mark. The sink can rebuild frame and line boundaries from these marks without counting bytes.

The machine arms only after it has seen both strobes low in the same clock. After that it waits for a frame to open with no line active. Both of its active states choose between three exits in a single clock: stay, leave the frame, or step between the line and no-line states. Because of this, no pixel clock is lost between a strobe edge and the sampling of data. Once armed, the machine never returns to its idle state, so it captures frame after frame until it is reset.

Top module: `cam_line_capture`

## Requirements
- R1: When `rst_n` is low at a clock edge, the machine returns to its idle state. One clock later `pix_vld_o`, `sof_o`, `eof_o` and `sol_o` are all 0.
- R2: From the idle state the machine arms (enters wait-for-frame) only on a clock where `frame_valid_i`=0 and `line_valid_i`=0. Any other combination keeps it idle, and it captures nothing.
- R3: In wait-for-frame the machine enters the in-frame state only on `frame_valid_i`=1 with `line_valid_i`=0. With both strobes high it keeps waiting and captures nothing.
- R4: On every clock where the machine is in-frame or sampling and both strobes are 1, `pix_o` takes `pix_i` and `pix_vld_o` is 1 one clock later. This includes the clock where `line_valid_i` rises, so a line of N active clocks gives exactly N words.
- R5: When `line_valid_i` falls while `frame_valid_i` stays 1, the machine drops back to in-frame and outputs no word. The next line is captured again.
- R6: `sof_o` is 1 together with the first word of each frame and on no other word.
- R7: `sol_o` is 1 together with the first word of each line and on no other word.
- R8: A clock with `frame_valid_i`=0 in the in-frame or sampling state gives a one-cycle `eof_o` a clock later and returns the machine to wait-for-frame, not to idle. The next frame is then armed by `frame_valid_i`=1, `line_valid_i`=0 with no all-low clock needed.
- R9: `line_valid_i`=1 while `frame_valid_i`=0 is ignored: `pix_vld_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock from the sensor, clocks the whole block |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_valid_i | input | 1 | Frame qualifier strobe |
| line_valid_i | input | 1 | Line qualifier strobe |
| pix_i | input | DATA_W | Pixel word from the sensor |
| pix_o | output | DATA_W | Captured pixel word |
| pix_vld_o | output | 1 | `pix_o` holds a new word this clock |
| sof_o | output | 1 | Word is the first of a frame |
| eof_o | output | 1 | Frame has just closed |
| sol_o | output | 1 | Word is the first of a line |

## Verification
The bench builds the block with `DATA_W` = 8, so each captured word can be matched against a distinct byte driven on its clock. A vector table steps through arming order, the rejected strobe combinations, single-word and multi-word lines, and frames that close while a line is still active. Directed runs then drive a 20-pixel line to confirm that the word count is exact, and reset the block in mid-line to confirm that it must re-arm from an all-low clock.

// File: rtl/cam_cap_pkg.sv
// Shared types for the camera capture block.
package cam_cap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_FRAME = 2'd1,
        ST_IN_FRAME   = 2'd2,
        ST_SAMPLE     = 2'd3
    } cap_state_e;
endpackage

// File: rtl/cam_fsm.sv
// Strobe tracking state machine.
// Decides in one clock between staying, leaving the frame and moving
// between line and no-line, and produces combinational capture strobes.
// Assumes the strobes are synchronous to clk.
module cam_fsm
    import cam_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fv_i,
    input  logic       lv_i,
    output cap_state_e state_o,
    output logic       capture_o,
    output logic       line_first_o,
    output logic       frame_first_o,
    output logic       frame_end_o
);
    cap_state_e state_q, state_d;
    logic       first_pend_q;
    logic       active;

    assign active = (state_q == ST_IN_FRAME) || (state_q == ST_SAMPLE);

    // Next-state choice: three-way exits from the active states.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (!fv_i && !lv_i) state_d = ST_WAIT_FRAME;
            ST_WAIT_FRAME: if (fv_i && !lv_i)  state_d = ST_IN_FRAME;
            ST_IN_FRAME: begin
                if (!fv_i)     state_d = ST_WAIT_FRAME;
                else if (lv_i) state_d = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                if (!fv_i)      state_d = ST_WAIT_FRAME;
                else if (!lv_i) state_d = ST_IN_FRAME;
            end
            default:       state_d = ST_IDLE;
        endcase
    end

    // Combinational strobes toward the output stage.
    assign capture_o     = active && fv_i && lv_i;
    assign line_first_o  = capture_o && (state_q == ST_IN_FRAME);
    assign frame_first_o = capture_o && first_pend_q;
    assign frame_end_o   = active && !fv_i;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Remembers that the current frame has not delivered a word yet.
    always_ff @(posedge clk) begin
        if (!rst_n)
            first_pend_q <= 1'b0;
        else if (state_q == ST_WAIT_FRAME && state_d == ST_IN_FRAME)
            first_pend_q <= 1'b1;
        else if (capture_o)
            first_pend_q <= 1'b0;
    end

    assign state_o = state_q;
endmodule

// File: rtl/cam_out_stage.sv
// Output register stage.
// Registers the pixel word and the framing marks one clock after the
// strobes that select them. The word holds its value between captures.
module cam_out_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              line_first_i,
    input  logic              frame_first_i,
    input  logic              frame_end_i,
    input  logic [DATA_W-1:0] pix_i,
    output logic [DATA_W-1:0] pix_o,
    output logic              vld_o,
    output logic              sof_o,
    output logic              eof_o,
    output logic              sol_o
);
    // Data word: loads only on capture.
    always_ff @(posedge clk) begin
        if (!rst_n)         pix_o <= '0;
        else if (capture_i) pix_o <= pix_i;
    end

    // Single-cycle qualifier and mark register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            sof_o <= 1'b0;
            eof_o <= 1'b0;
            sol_o <= 1'b0;
        end else begin
            vld_o <= capture_i;
            sof_o <= frame_first_i;
            eof_o <= frame_end_i;
            sol_o <= line_first_i;
        end
    end
endmodule

// File: rtl/cam_line_capture.sv
// Camera frame and line capture top.
// Clocked by the sensor pixel clock; forwards each active pixel with
// frame and line marks, one clock of latency. Synchronous active-low reset.
module cam_line_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid_i,
    input  logic              line_valid_i,
    input  logic [DATA_W-1:0] pix_i,
    output logic [DATA_W-1:0] pix_o,
    output logic              pix_vld_o,
    output logic              sof_o,
    output logic              eof_o,
    output logic              sol_o
);
    import cam_cap_pkg::*;

    cap_state_e state_w;
    logic       capture_w, line_first_w, frame_first_w, frame_end_w;

    cam_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .fv_i          (frame_valid_i),
        .lv_i          (line_valid_i),
        .state_o       (state_w),
        .capture_o     (capture_w),
        .line_first_o  (line_first_w),
        .frame_first_o (frame_first_w),
        .frame_end_o   (frame_end_w)
    );

    cam_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .capture_i     (capture_w),
        .line_first_i  (line_first_w),
        .frame_first_i (frame_first_w),
        .frame_end_i   (frame_end_w),
        .pix_i         (pix_i),
        .pix_o         (pix_o),
        .vld_o         (pix_vld_o),
        .sof_o         (sof_o),
        .eof_o         (eof_o),
        .sol_o         (sol_o)
    );
endmodule

// File: rtl/cam_line_capture_chk.sv
// Property checker for cam_line_capture, bound to every instance.
module cam_line_capture_chk
    import cam_cap_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_valid_i,
    input logic              line_valid_i,
    input logic [DATA_W-1:0] pix_i,
    input logic [DATA_W-1:0] pix_o,
    input logic              pix_vld_o,
    input logic              sof_o,
    input logic              eof_o,
    input logic              sol_o,
    input cap_state_e        state_w
);
    // R4: an active clock with both strobes high yields the word next clock
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid_i && line_valid_i &&
         (state_w == ST_IN_FRAME || state_w == ST_SAMPLE))
        |=> (pix_vld_o && pix_o == $past(pix_i)));

    // R9: no word while the frame strobe is low
    a_r9_ignore_line: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid_i |=> !pix_vld_o);

    // R6: frame mark travels with a word
    a_r6_sof_word: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |-> pix_vld_o);

    // R7: line mark travels with a word
    a_r7_sol_word: assert property (@(posedge clk) disable iff (!rst_n)
        sol_o |-> pix_vld_o);

    // R8: end mark only after a low frame strobe, never with a word
    a_r8_eof_cause: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |-> (!$past(frame_valid_i) && !pix_vld_o));

    // R8: once armed the machine never returns to idle
    a_r8_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w != ST_IDLE) |=> (state_w != ST_IDLE));

    // R2: idle is left only after an all-low clock
    a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_IDLE && (frame_valid_i || line_valid_i))
        |=> (state_w == ST_IDLE));
endmodule

bind cam_line_capture cam_line_capture_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_valid_i (frame_valid_i),
    .line_valid_i  (line_valid_i),
    .pix_i         (pix_i),
    .pix_o         (pix_o),
    .pix_vld_o     (pix_vld_o),
    .sof_o         (sof_o),
    .eof_o         (eof_o),
    .sol_o         (sol_o),
    .state_w       (state_w)
);

// File: tb/tb_cam_line_capture.sv
// Self-checking bench for cam_line_capture.
module tb_cam_line_capture;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    typedef struct packed {
        logic [3:0] req;
        logic       fv;
        logic       lv;
        logic [7:0] d;
        logic       vld;
        logic       sof;
        logic       eof;
        logic       sol;
    } vec_t;

    localparam int NV = 24;
    // each vector: requirement, strobes, data, expected vld/sof/eof/sol
    localparam vec_t VECS [NV] = '{
        '{4'd2, 1'b1, 1'b1, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 not armed
        '{4'd2, 1'b1, 1'b0, 8'hAB, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 not armed
        '{4'd2, 1'b0, 1'b0, 8'hAC, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 arms
        '{4'd9, 1'b0, 1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 ignored
        '{4'd3, 1'b1, 1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 keeps waiting
        '{4'd3, 1'b1, 1'b0, 8'h23, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 in-frame
        '{4'd6, 1'b1, 1'b1, 8'h31, 1'b1, 1'b1, 1'b0, 1'b1}, // R6 R7 first word
        '{4'd4, 1'b1, 1'b1, 8'h32, 1'b1, 1'b0, 1'b0, 1'b0}, // R4
        '{4'd4, 1'b1, 1'b1, 8'h33, 1'b1, 1'b0, 1'b0, 1'b0}, // R4
        '{4'd5, 1'b1, 1'b0, 8'h34, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 line gap
        '{4'd7, 1'b1, 1'b1, 8'h41, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 second line
        '{4'd4, 1'b1, 1'b1, 8'h42, 1'b1, 1'b0, 1'b0, 1'b0}, // R4
        '{4'd8, 1'b0, 1'b0, 8'h43, 1'b0, 1'b0, 1'b1, 1'b0}, // R8 end
        '{4'd8, 1'b1, 1'b0, 8'h44, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 re-arm
        '{4'd6, 1'b1, 1'b1, 8'h51, 1'b1, 1'b1, 1'b0, 1'b1}, // R6 new frame
        '{4'd8, 1'b0, 1'b1, 8'h52, 1'b0, 1'b0, 1'b1, 1'b0}, // R8 end mid-line
        '{4'd9, 1'b0, 1'b1, 8'h53, 1'b0, 1'b0, 1'b0, 1'b0}, // R9
        '{4'd8, 1'b1, 1'b0, 8'h54, 1'b0, 1'b0, 1'b0, 1'b0}, // R8
        '{4'd8, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0, 1'b1, 1'b0}, // R8 empty frame
        '{4'd8, 1'b1, 1'b0, 8'h56, 1'b0, 1'b0, 1'b0, 1'b0}, // R8
        '{4'd6, 1'b1, 1'b1, 8'h61, 1'b1, 1'b1, 1'b0, 1'b1}, // R6 one-word line
        '{4'd5, 1'b1, 1'b0, 8'h62, 1'b0, 1'b0, 1'b0, 1'b0}, // R5
        '{4'd7, 1'b1, 1'b1, 8'h71, 1'b1, 1'b0, 1'b0, 1'b1}, // R7
        '{4'd8, 1'b0, 1'b0, 8'h72, 1'b0, 1'b0, 1'b1, 1'b0}  // R8
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fv = 1'b1;
    logic          lv = 1'b1;
    logic [DW-1:0] pix = '0;
    logic [DW-1:0] pix_o;
    logic          vld, sof, eof, sol;
    int            n_run = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    cam_line_capture #(.DATA_W(DW)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_valid_i (fv),
        .line_valid_i  (lv),
        .pix_i         (pix),
        .pix_o         (pix_o),
        .pix_vld_o     (vld),
        .sof_o         (sof),
        .eof_o         (eof),
        .sol_o         (sol)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // drive at the falling edge, let one rising edge pass, return at the next fall
    task automatic step(input logic f, input logic l, input logic [DW-1:0] d);
        fv = f; lv = l; pix = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic e_vld, input logic [DW-1:0] e_d,
                       input logic e_sof, input logic e_eof, input logic e_sol);
        n_run++;
        if (vld !== e_vld || sof !== e_sof || eof !== e_eof || sol !== e_sol ||
            (e_vld && pix_o !== e_d)) begin
            n_fail++;
            $display("FAIL %s: vld/sof/eof/sol/data = %b%b%b%b/%h expected %b%b%b%b/%h",
                     req, vld, sof, eof, sol, pix_o, e_vld, e_sof, e_eof, e_sol, e_d);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        step(1'b1, 1'b1, 8'h00);
        step(1'b1, 1'b1, 8'h00);
        chk("R1 reset state", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].fv, VECS[i].lv, VECS[i].d);
            chk($sformatf("R%0d vector %0d", VECS[i].req, i),
                VECS[i].vld, VECS[i].d, VECS[i].sof, VECS[i].eof, VECS[i].sol);
        end

        // R4: a 20-pixel line gives exactly 20 words, none dropped
        step(1'b1, 1'b0, 8'h00);
        chk("R3 enter frame", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        begin
            int got = 0;
            for (int k = 0; k < 20; k++) begin
                step(1'b1, 1'b1, 8'(8'h80 + k));
                if (vld) got++;
                chk("R4 long line", 1'b1, 8'(8'h80 + k), k == 0, 1'b0, k == 0);
            end
            step(1'b1, 1'b0, 8'hEE);
            if (vld) got++;
            chk("R5 after long line", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
            n_run++;
            if (got != 20) begin
                n_fail++;
                $display("FAIL R4 word count: %0d expected 20", got);
            end
        end

        // R1: reset mid-line, then the block must re-arm from idle (R2)
        step(1'b1, 1'b1, 8'h90);
        chk("R4 before reset", 1'b1, 8'h90, 1'b0, 1'b0, 1'b1);
        rst_n = 1'b0;
        step(1'b1, 1'b1, 8'h91);
        chk("R1 reset mid-line", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 8'h92);
        chk("R2 idle ignores frame", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 8'h93);
        chk("R2 idle ignores line", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 8'h94);
        chk("R2 arm", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 8'h95);
        chk("R3 frame opens", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 8'h9C);
        chk("R6 first word after reset", 1'b1, 8'h9C, 1'b1, 1'b0, 1'b1);
        step(1'b0, 1'b0, 8'h9D);
        chk("R8 close after reset", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);

        finish_run();
    end
endmodule